// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for 32-bit byte addresses with 4 KB pages. A lookup takes the upper 20 bits of the address as the virtual page number and compares them against every valid entry at once. On a match, the physical address is returned in the same cycle, formed from the stored physical page number and the unchanged 12-bit offset.

Each hit is checked against the entry's read, write, execute and user-access rights for the requested access kind and privilege mode. A denied access is reported as a protection fault, and no address is produced. A lookup with no match reports a miss.

An external page table walker writes translations through a refill port. The refill goes to a matching entry if one exists, otherwise to the lowest free entry, otherwise to a round-robin victim. A write that hits marks its entry dirty. When a dirty victim is displaced, the block presents the victim's virtual page number for one cycle so that the page table entry can be marked modified. A flush input empties the buffer.

Top module: `xlate_buffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss.
- R2: A permitted hit asserts `lk_hit` in the same cycle, with `lk_paddr` = {stored 20-bit physical page, `lk_vaddr[11:0]`}.
- R3: An entry that is not valid never matches. A lookup whose page matches no valid entry asserts `lk_miss`.
- R4: Access kind is encoded on `lk_kind` as 0 = read, 1 = write, 2 = fetch, and 3 is treated as a read. The right needed is `rf_perm[0]` (read), `rf_perm[1]` (write) or `rf_perm[2]` (execute). A hit lacking that right asserts `lk_fault` instead of `lk_hit`, and `lk_paddr` is then 0.
- R5: When `lk_user` is 1 and the entry's user bit `rf_perm[3]` is 0, the hit faults. In kernel mode (`lk_user` = 0) the user bit is ignored.
- R6: A write lookup that hits without fault marks that entry dirty.
- R7: A refill whose page matches a valid entry overwrites that entry, keeping its dirty flag. No second copy is made, and the round-robin pointer does not move.
- R8: A refill for a new page goes to the lowest-numbered invalid entry while any entry is invalid. The new entry starts clean.
- R9: When all entries are valid, a refill for a new page replaces the entry at the round-robin pointer, which starts at 0, advances by one per such replacement, and wraps. If the victim is dirty (including a permitted write hit on it in the same cycle), `wb_valid` is 1 in that cycle and `wb_vpn` holds the victim's page; otherwise `wb_valid` is 0 and `wb_vpn` is 0.
- R10: `flush` invalidates every entry and clears all dirty flags in one cycle, and a refill in the same cycle is dropped.
- R11: At most one of `lk_hit`, `lk_miss`, `lk_fault` is high, and all are low when `lk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual byte address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Permitted hit |
| lk_miss | output | 1 | No valid entry matches |
| lk_fault | output | 1 | Hit denied by rights |
| lk_paddr | output | 32 | Physical address on a permitted hit, else 0 |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | 20 | Refill virtual page |
| rf_ppn | input | 20 | Refill physical page |
| rf_perm | input | 4 | Rights: bit0 read, bit1 write, bit2 execute, bit3 user |
| wb_valid | output | 1 | Dirty victim displaced this cycle |
| wb_vpn | output | 20 | Page of the displaced dirty victim |

## Verification
The bench targets the transition from filling free slots to evicting entries. A design that kept filling past the last free slot, or started the pointer elsewhere, would evict the wrong page and report the wrong page for write-back. Re-refilling a present page must not duplicate it or lose its dirty mark: a duplicate would leave stale translations and skew later eviction order. Rights checks in user mode against supervisor pages, and flush colliding with a refill, are driven both directly and in a long random phase. In that phase a faulty priority shows up as a stray hit.

// File: rtl/xlate_buffer.sv
module xlate_buffer #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic [1:0]         lk_kind,
  input  logic               lk_user,
  output logic               lk_hit,
  output logic               lk_miss,
  output logic               lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  input  logic               rf_valid,
  input  logic [VA_W-OFF_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0]   rf_ppn,
  input  logic [3:0]         rf_perm,
  output logic               wb_valid,
  output logic [VA_W-OFF_W-1:0] wb_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, drt;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [3:0]         prm [ENTRIES];
  logic [IDX_W-1:0]   ptr;

  logic [VPN_W-1:0] vpn;
  logic             any_hit, rf_match, ok, wr_set, use_ptr;
  logic [IDX_W-1:0] hidx, ridx, fidx, fill_idx;
  logic [3:0]       hp;

  assign vpn = lk_vaddr[VA_W-1:OFF_W];

  always_comb begin
    any_hit = 1'b0; rf_match = 1'b0;
    hidx = '0; ridx = '0; fidx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (vld[i] && tag[i] == vpn)    begin any_hit = 1'b1;  hidx = IDX_W'(i); end
      if (vld[i] && tag[i] == rf_vpn) begin rf_match = 1'b1; ridx = IDX_W'(i); end
      if (!vld[i]) fidx = IDX_W'(i);
    end
  end

  assign hp = prm[hidx];
  always_comb begin
    case (lk_kind)
      2'd1:    ok = hp[1];
      2'd2:    ok = hp[2];
      default: ok = hp[0];
    endcase
    if (lk_user && !hp[3]) ok = 1'b0;
  end

  assign lk_hit   = lk_valid && any_hit && ok;
  assign lk_fault = lk_valid && any_hit && !ok;
  assign lk_miss  = lk_valid && !any_hit;
  assign lk_paddr = lk_hit ? {ppn[hidx], lk_vaddr[OFF_W-1:0]} : '0;
  assign wr_set   = lk_hit && lk_kind == 2'd1;

  assign use_ptr  = rf_valid && !flush && !rf_match && (&vld);
  assign fill_idx = rf_match ? ridx : (&vld) ? ptr : fidx;
  assign wb_valid = use_ptr && (drt[ptr] || (wr_set && hidx == ptr));
  assign wb_vpn   = wb_valid ? tag[ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
      drt <= '0;
      if (!rst_n) ptr <= '0;
    end else begin
      if (wr_set) drt[hidx] <= 1'b1;
      if (rf_valid) begin
        vld[fill_idx] <= 1'b1;
        if (!rf_match) drt[fill_idx] <= 1'b0;
      end
      if (use_ptr) ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && rf_valid) begin
      tag[fill_idx] <= rf_vpn;
      ppn[fill_idx] <= rf_ppn;
      prm[fill_idx] <= rf_perm;
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);
  p_fault_noaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_paddr == '0);
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit && !lk_fault);
  p_wb_needs_refill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> rf_valid && !flush);
endmodule

// File: tb/tb_xlate_buffer.sv
`timescale 1ns/1ps
module tb_xlate_buffer;
  localparam int N = 32;
  logic clk = 0, rst_n = 0, flush = 0, lk_valid = 0, lk_user = 0, rf_valid = 0;
  logic [31:0] lk_vaddr = 0;
  logic [1:0]  lk_kind = 0;
  logic [19:0] rf_vpn = 0, rf_ppn = 0;
  logic [3:0]  rf_perm = 0;
  logic lk_hit, lk_miss, lk_fault, wb_valid;
  logic [31:0] lk_paddr;
  logic [19:0] wb_vpn;

  always #2 clk = ~clk;

  xlate_buffer dut (.clk, .rst_n, .flush, .lk_valid, .lk_vaddr, .lk_kind, .lk_user,
    .lk_hit, .lk_miss, .lk_fault, .lk_paddr, .rf_valid, .rf_vpn, .rf_ppn, .rf_perm,
    .wb_valid, .wb_vpn);

  bit m_vld[N], m_drt[N];
  logic [19:0] m_tag[N], m_ppn[N];
  logic [3:0]  m_prm[N];
  int m_ptr = 0;
  int total = 0, bad = 0;

  task automatic step(string req);
    int h, r, f, v;
    bit e_hit, e_miss, e_flt, ok, e_wb, full;
    logic [31:0] e_pa;
    logic [19:0] e_wv;
    #1;
    h = -1; r = -1; f = -1; full = 1;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i] && m_tag[i] == lk_vaddr[31:12] && h < 0) h = i;
      if (m_vld[i] && m_tag[i] == rf_vpn && r < 0) r = i;
      if (!m_vld[i] && f < 0) f = i;
      if (!m_vld[i]) full = 0;
    end
    ok = 0;
    if (h >= 0) begin
      ok = (lk_kind == 1) ? m_prm[h][1] : (lk_kind == 2) ? m_prm[h][2] : m_prm[h][0];
      if (lk_user && !m_prm[h][3]) ok = 0;
    end
    e_hit = lk_valid && h >= 0 && ok;
    e_flt = lk_valid && h >= 0 && !ok;
    e_miss = lk_valid && h < 0;
    e_pa = e_hit ? {m_ppn[h], lk_vaddr[11:0]} : 32'd0;
    v = (r >= 0) ? r : full ? m_ptr : f;
    e_wb = rf_valid && !flush && r < 0 && full &&
           (m_drt[m_ptr] || (e_hit && lk_kind == 1 && h == m_ptr));
    e_wv = e_wb ? m_tag[m_ptr] : 20'd0;
    total++;
    if ({lk_hit, lk_miss, lk_fault, lk_paddr, wb_valid, wb_vpn} !==
        {e_hit, e_miss, e_flt, e_pa, e_wb, e_wv}) begin
      bad++;
      $display("FAIL %s: got hit=%b miss=%b flt=%b pa=%h wb=%b wv=%h exp hit=%b miss=%b flt=%b pa=%h wb=%b wv=%h",
        req, lk_hit, lk_miss, lk_fault, lk_paddr, wb_valid, wb_vpn,
        e_hit, e_miss, e_flt, e_pa, e_wb, e_wv);
    end
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_drt[i] = 0; end
    end else begin
      if (e_hit && lk_kind == 1) m_drt[h] = 1;
      if (rf_valid) begin
        m_vld[v] = 1; m_tag[v] = rf_vpn; m_ppn[v] = rf_ppn; m_prm[v] = rf_perm;
        if (r < 0) m_drt[v] = 0;
        if (r < 0 && full) m_ptr = (m_ptr + 1) % N;
      end
    end
    #1;
  endtask

  task automatic idle();
    lk_valid = 0; rf_valid = 0; flush = 0;
  endtask
  task automatic look(logic [31:0] a, logic [1:0] k, logic u, string req);
    idle(); lk_valid = 1; lk_vaddr = a; lk_kind = k; lk_user = u; step(req);
  endtask
  task automatic fill(logic [19:0] vp, logic [19:0] pp, logic [3:0] pm, string req);
    idle(); rf_valid = 1; rf_vpn = vp; rf_ppn = pp; rf_perm = pm; step(req);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look(32'h12345678, 0, 0, "R1 reset empty");
    idle(); step("R11 idle quiet");
    fill(20'h00010, 20'hABCDE, 4'hF, "R8 first free");
    look(32'h00010123, 0, 1, "R2 hit paddr");
    look(32'h00011000, 0, 0, "R3 miss");
    fill(20'h00020, 20'h0C0DE, 4'h1, "R8 second free");
    look(32'h00020004, 1, 0, "R4 write denied");
    look(32'h00020008, 2, 0, "R4 fetch denied");
    look(32'h00020008, 3, 0, "R4 kind3 read");
    look(32'h00020FFC, 0, 0, "R5 kernel ok");
    look(32'h00020FFC, 0, 1, "R5 user supervisor page");
    look(32'h00010040, 1, 1, "R6 write sets dirty");
    fill(20'h00010, 20'h55555, 4'hF, "R7 overwrite");
    look(32'h00010ABC, 2, 0, "R7 new ppn");
    for (int i = 0; i < N - 2; i++) fill(20'h00100 + 20'(i), 20'h30000 + 20'(i), 4'h7, "R8 fill");
    fill(20'h00999, 20'h09999, 4'hF, "R9 dirty victim");
    fill(20'h0099A, 20'h0999A, 4'hF, "R9 clean victim");
    look(32'h00010000, 0, 0, "R9 evicted gone");
    look(32'h0099A010, 0, 1, "R9 new entry");
    idle(); flush = 1; rf_valid = 1; rf_vpn = 20'h00777; rf_ppn = 20'h1; rf_perm = 4'hF;
    step("R10 flush beats refill");
    look(32'h00777000, 0, 0, "R10 refill dropped");
    look(32'h0099A000, 0, 0, "R10 flushed");
    for (int c = 0; c < 3000; c++) begin
      lk_valid = 1'($urandom);
      lk_vaddr = {15'd0, 5'($urandom), 12'($urandom)};
      lk_kind = 2'($urandom);
      lk_user = 1'($urandom);
      rf_valid = 1'($urandom);
      rf_vpn = {15'd0, 5'($urandom)} + 20'd0;
      rf_ppn = 20'($urandom);
      rf_perm = 4'($urandom);
      flush = ($urandom % 64) == 0;
      step("R9 R7 R4 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule